// File: doc/BRIEF.md
# FPGA Warm-Reboot Command Sequencer

This block lets software make an FPGA reload its configuration from another location in the boot flash. Software writes a 32-bit flash start address through a byte-wide register port, one byte per offset. It then writes a magic value to a trigger offset. The sequencer then feeds the device's internal configuration port with a fixed 16-word command stream, one word per clock. The stream contains dummy padding, a sync word, the start-address register write, the reload command and NOOP spacers. The address word is patched in when the trigger is accepted.

Each word has the bit order inside every byte reversed, because the configuration port expects that. While a word is on the bus, the active-low port enable and the active-low write select are both driven low. Everywhere else they stay high. The block drives only the write side of the port.

The control is a two-state machine:
- `ST_IDLE` waits for an accepted trigger. Transition "launch": a magic write moves it to `ST_SEND` with the word index at 0.
- `ST_SEND` steps the index once per clock. Transition "finish": at the last index it returns to `ST_IDLE`.

Top module: `warm_reboot_seq`

## Requirements
- R1: After a synchronous reset the four address bytes are zero, the block is idle, and a sequence launched straight away carries start address 0x00000000.
- R2: While idle, `cfg_en_n` and `cfg_wr_n` are 1, `busy` is 0 and `cfg_data` is 0xFFFFFFFF.
- R3: A register write of exactly 0x42 to offset 0xCF launches a sequence. Any other value at 0xCF, and a write of 0x42 to any other offset, leaves the block idle.
- R4: Offsets 0xC8, 0xC9, 0xCA and 0xCB hold address bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R5: The raw words, by index 0 to 15, are: 0xFFFFFFFF five times, 0xAA995566, 0x20000000 twice, 0x30020001, the start address, 0x20000000 twice, 0x30008001, 0x0000000F, and 0x20000000 twice.
- R6: Each word on `cfg_data` is the raw word with the 8 bits of every byte mirrored, so bit 8k+j carries raw bit 8k+7-j.
- R7: Word 0 appears in the cycle after the clock edge that accepts the trigger. `cfg_en_n` and `cfg_wr_n` are then low for exactly 16 consecutive cycles, one word per cycle, and high afterwards.
- R8: A trigger write while a sequence runs neither restarts it nor extends it.
- R9: The address sent is the register value at trigger acceptance. Address writes during a sequence do not change it, but they do apply to the next sequence.
- R10: `busy` is 1 exactly in the 16 cycles in which words are emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_offs | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| cfg_en_n | output | 1 | Configuration port enable, active low |
| cfg_wr_n | output | 1 | Configuration port write select, low for write |
| cfg_data | output | 32 | Bit-reversed command word |
| busy | output | 1 | High while the sequence is emitted |

## Verification
The bench launches sequences with random addresses and compares every emitted word against its own table and byte-mirroring function. A wrong byte order or wrong lane mapping would show up as a corrupted address slot. The bench fires near-miss trigger values and the right value at a neighbouring offset; a loose decode would start a spurious reboot.

The bench also injects a trigger and an address write in the middle of a run. A design that restarts on the trigger would emit more than 16 words. A design that reads the live register would send a mixed address. Launching straight after reset checks that the address is cleared.

// File: rtl/wreboot_pkg.sv
package wreboot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SEND
    } seq_state_t;

    localparam logic [31:0] CW_PAD       = 32'hFFFF_FFFF;
    localparam logic [31:0] CW_SYNC      = 32'hAA99_5566;
    localparam logic [31:0] CW_NOOP      = 32'h2000_0000;
    localparam logic [31:0] CW_HDR_START = 32'h3002_0001;
    localparam logic [31:0] CW_HDR_CMD   = 32'h3000_8001;
    localparam logic [31:0] CW_RELOAD    = 32'h0000_000F;

endpackage

// File: rtl/wr_addr_regs.sv
module wr_addr_regs #(
    parameter int          OFFS_W  = 8,
    parameter int          DATA_W  = 8,
    parameter int          LANES   = 4,
    parameter logic [7:0]  BASE    = 8'hC8,
    parameter logic [7:0]  TRIG    = 8'hCF,
    parameter logic [7:0]  MAGIC   = 8'h42
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [OFFS_W-1:0]         offs,
    input  logic [DATA_W-1:0]         wdata,
    output logic [LANES*DATA_W-1:0]   start_addr,
    output logic                      trig_hit
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (wr_en && offs == OFFS_W'(BASE + b))
                lane_q <= wdata;
        end
        assign start_addr[b*DATA_W +: DATA_W] = lane_q;
    end

    assign trig_hit = wr_en && (offs == OFFS_W'(TRIG)) && (wdata == DATA_W'(MAGIC));

    a_r4_low_lane: assert property (@(posedge clk) disable iff (rst)
        (wr_en && offs == OFFS_W'(BASE)) |=> start_addr[DATA_W-1:0] == $past(wdata));

    a_r4_top_lane: assert property (@(posedge clk) disable iff (rst)
        (wr_en && offs == OFFS_W'(BASE + LANES - 1))
            |=> start_addr[LANES*DATA_W-1 -: DATA_W] == $past(wdata));

endmodule

// File: rtl/wr_word_table.sv
module wr_word_table
    import wreboot_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] word_rev
);

    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] raw;

    always_comb begin
        case (idx)
            IDX_W'(0), IDX_W'(1), IDX_W'(2),
            IDX_W'(3), IDX_W'(4):                 raw = WORD_W'(CW_PAD);
            IDX_W'(5):                            raw = WORD_W'(CW_SYNC);
            IDX_W'(6), IDX_W'(7),
            IDX_W'(10), IDX_W'(11),
            IDX_W'(14), IDX_W'(15):               raw = WORD_W'(CW_NOOP);
            IDX_W'(8):                            raw = WORD_W'(CW_HDR_START);
            IDX_W'(9):                            raw = addr;
            IDX_W'(12):                           raw = WORD_W'(CW_HDR_CMD);
            IDX_W'(13):                           raw = WORD_W'(CW_RELOAD);
            default:                              raw = WORD_W'(CW_PAD);
        endcase
    end

    for (genvar by = 0; by < NBYTES; by++) begin : g_byte
        for (genvar bt = 0; bt < 8; bt++) begin : g_bit
            assign word_rev[by*8 + bt] = raw[by*8 + 7 - bt];
        end
    end

endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
    import wreboot_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SEQ_LEN = 16,
    parameter int IDX_W   = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [WORD_W-1:0] addr_in,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] addr_lat,
    output logic              port_en_n,
    output logic              port_wr_n,
    output logic              sending
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            addr_lat <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state    <= ST_SEND;
                        idx      <= '0;
                        addr_lat <= addr_in;
                    end
                end
                ST_SEND: begin
                    if (idx == LAST)
                        state <= ST_IDLE;
                    else
                        idx <= idx + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        port_en_n = 1'b1;
        port_wr_n = 1'b1;
        sending   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: begin
                port_en_n = 1'b0;
                port_wr_n = 1'b0;
                sending   = 1'b1;
            end
        endcase
    end

    a_r3_launch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && trig) |=> (state == ST_SEND && idx == '0));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && idx != LAST) |=> (state == ST_SEND && idx == $past(idx) + 1'b1));

    a_r7_finish: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && idx == LAST) |=> state == ST_IDLE);

    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) |=> $stable(addr_lat));

endmodule

// File: rtl/warm_reboot_seq.sv
module warm_reboot_seq
    import wreboot_pkg::*;
#(
    parameter int OFFS_W  = 8,
    parameter int WORD_W  = 32,
    parameter int SEQ_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [OFFS_W-1:0] reg_offs,
    input  logic [7:0]        reg_wdata,
    output logic              cfg_en_n,
    output logic              cfg_wr_n,
    output logic [WORD_W-1:0] cfg_data,
    output logic              busy
);

    localparam int IDX_W = $clog2(SEQ_LEN);
    localparam int LANES = WORD_W / 8;

    logic [WORD_W-1:0] start_addr;
    logic              trig_hit;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] addr_lat;
    logic [WORD_W-1:0] word_rev;

    wr_addr_regs #(
        .OFFS_W (OFFS_W),
        .DATA_W (8),
        .LANES  (LANES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .offs       (reg_offs),
        .wdata      (reg_wdata),
        .start_addr (start_addr),
        .trig_hit   (trig_hit)
    );

    wr_seq_fsm #(
        .WORD_W  (WORD_W),
        .SEQ_LEN (SEQ_LEN),
        .IDX_W   (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig_hit),
        .addr_in   (start_addr),
        .idx       (idx),
        .addr_lat  (addr_lat),
        .port_en_n (cfg_en_n),
        .port_wr_n (cfg_wr_n),
        .sending   (busy)
    );

    wr_word_table #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_table (
        .idx      (idx),
        .addr     (addr_lat),
        .word_rev (word_rev)
    );

    assign cfg_data = busy ? word_rev : '1;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cfg_en_n && cfg_wr_n && cfg_data == '1));

    a_r7_pins_agree: assert property (@(posedge clk) disable iff (rst)
        cfg_en_n == cfg_wr_n);

endmodule

// File: tb/warm_reboot_seq_test.sv
module warm_reboot_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_offs;
    logic [7:0]  reg_wdata;
    logic        cfg_en_n;
    logic        cfg_wr_n;
    logic [31:0] cfg_data;
    logic        busy;

    int checks = 0;
    int errors = 0;
    logic [31:0] mirror;

    always #5 clk = ~clk;

    warm_reboot_seq uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_offs  (reg_offs),
        .reg_wdata (reg_wdata),
        .cfg_en_n  (cfg_en_n),
        .cfg_wr_n  (cfg_wr_n),
        .cfg_data  (cfg_data),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mirror_bytes(input logic [31:0] w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int j = 0; j < 8; j++)
                r[b*8 + j] = w[b*8 + 7 - j];
        return r;
    endfunction

    function automatic logic [31:0] expect_raw(input int i, input logic [31:0] a);
        if (i < 5) return 32'hFFFFFFFF;
        case (i)
            5:  return 32'hAA995566;
            8:  return 32'h30020001;
            9:  return a;
            12: return 32'h30008001;
            13: return 32'h0000000F;
            default: return 32'h20000000;
        endcase
    endfunction

    task automatic reg_write(input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_offs  = o;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        for (int b = 0; b < 4; b++) reg_write(8'hC8 + 8'(b), a[b*8 +: 8]);
        mirror = a;
    endtask

    task automatic check_idle(input string req);
        chk(cfg_en_n === 1'b1, req, 32'(cfg_en_n), 32'd1);
        chk(cfg_wr_n === 1'b1, req, 32'(cfg_wr_n), 32'd1);
        chk(busy === 1'b0, req, 32'(busy), 32'd0);
        chk(cfg_data === 32'hFFFFFFFF, req, cfg_data, 32'hFFFFFFFF);
    endtask

    // Launch and check all 16 words; optional mid-run trigger (R8) and address write (R9).
    task automatic run_seq(input bit interfere);
        logic [31:0] sent = mirror;
        reg_write(8'hCF, 8'h42);
        for (int k = 0; k < 16; k++) begin
            chk(cfg_data === mirror_bytes(expect_raw(k, sent)), "R5/R6 word", cfg_data,
                mirror_bytes(expect_raw(k, sent)));
            chk(cfg_en_n === 1'b0 && cfg_wr_n === 1'b0, "R7 strobes low",
                {cfg_en_n, cfg_wr_n}, 32'd0);
            chk(busy === 1'b1, "R10 busy high", 32'(busy), 32'd1);
            reg_wr_en = 1'b0;
            if (interfere && k == 2) begin
                reg_wr_en = 1'b1; reg_offs = 8'hCF; reg_wdata = 8'h42;
            end
            if (interfere && k == 4) begin
                reg_wr_en = 1'b1; reg_offs = 8'hC9; reg_wdata = ~mirror[15:8];
                mirror[15:8] = ~mirror[15:8];
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        check_idle("R7/R8/R10 idle after 16 words");
        @(negedge clk);
        check_idle("R8 no extension");
    endtask

    initial begin
        #100us;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] bad [5];
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        rst = 1'b1; reg_wr_en = 1'b0; reg_offs = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        check_idle("R1/R2 reset idle");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R2 idle");

        // R1: launch straight after reset, address must be zero
        mirror = 32'h0;
        run_seq(1'b0);

        // R3: near-miss triggers and wrong offset
        bad = '{8'h41, 8'h43, 8'hC2, 8'h00, 8'h42 ^ 8'h80};
        foreach (bad[i]) begin
            reg_write(8'hCF, bad[i]);
            check_idle("R3 bad magic ignored");
        end
        reg_write(8'hCE, 8'h42);
        check_idle("R3 wrong offset ignored");
        @(negedge clk);
        check_idle("R3 still idle");

        // R4: directed lane order
        set_addr(32'h1234_5678);
        run_seq(1'b0);

        // R8/R9: interference, then next run uses the new byte
        set_addr(32'hA5C3_0F81);
        run_seq(1'b1);
        run_seq(1'b0);

        for (int it = 0; it < 8; it++) begin
            set_addr($urandom);
            run_seq(it % 3 == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule